// File: doc/BRIEF.md
# Timestamped Event Lane Dispatcher

The dispatcher sits between a producer of timestamped output events and a set of lane FIFOs, eight by default. A later stage drains the lanes. Each event carries a fine timestamp and a data word. The coarse timestamp is the fine timestamp shifted right by three bits, and it decides lane placement. Inside every lane the coarse timestamps must rise strictly. For each lane the block keeps the coarse value of the last event written to it, and it keeps a pointer to the lane currently in use.

An event that cannot follow the current lane's last coarse value goes to the next lane in circular order whose last value is lower, or whose last value has been invalid since reset. If no lane qualifies, the event is consumed and dropped, and a one-cycle sequence error is flagged; the input stream keeps flowing. If the chosen lane is full, the block holds the input with backpressure.

An optional spreading mode avoids lanes that have reached a fill watermark. The block never reorders events and never looks ahead. A status output gives the free space left in the fullest lane.

Top module: `evt_lane_dispatcher`

## Requirements
- R1: After synchronous reset every lane is empty (`lane_valid` all 0), `min_free` equals DEPTH, `seq_err` is 0, `in_ready` is 1, the current lane is 0 and every lane's last coarse timestamp is invalid.
- R2: The coarse timestamp is `in_ts >> 3`. With spreading off, a stream whose coarse timestamps strictly increase is written entirely to the current lane.
- R3: When an event's coarse timestamp is not above the current lane's last value, the dispatcher tries lanes cur+1, cur+2, … in order, wrapping from lane LANES-1 to lane 0. It places the event in the first lane whose last value is lower or invalid, and that lane becomes current.
- R4: Two events whose fine timestamps differ but whose coarse timestamps are equal never go to the same lane back to back; the second one moves to the next lane.
- R5: If no lane can take the event, it is accepted (`in_ready` = 1) and discarded. `seq_err` is 1 for exactly the cycle after acceptance, and no lane content changes.
- R6: With spreading off, if the selected lane is full, `in_ready` is 0 and nothing is written. The event is placed, unchanged, in the cycle after that lane gets space.
- R7: With `spread_en` = 1, a lane holding HWM or more events is passed over in favour of the first later lane (in circular order) that can take the event and holds fewer than HWM. If no such lane exists, the rule of R3 applies.
- R8: `min_free` equals DEPTH minus the largest lane occupancy.
- R9: Each lane presents its oldest event on `lane_ts`/`lane_data` (lane i at bits [i*W +: W]) while `lane_valid[i]` is 1. `lane_pop[i]` removes that event. Lane order equals acceptance order.
- R10: A dropped event leaves the current lane unchanged.
- R11: From reset, adding a constant multiple of 8 to all timestamps of a sequence gives the same lane for every event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spread_en | input | 1 | Enables watermark-based lane spreading |
| in_valid | input | 1 | Event offered |
| in_ready | output | 1 | Event taken this cycle when valid |
| in_ts | input | TS_W | Fine timestamp |
| in_data | input | DATA_W | Event payload |
| seq_err | output | 1 | One-cycle pulse after an event was dropped |
| lane_valid | output | LANES | Lane i holds at least one event |
| lane_pop | input | LANES | Remove head of lane i |
| lane_ts | output | LANES*TS_W | Head timestamps, lane i at [i*TS_W +: TS_W] |
| lane_data | output | LANES*DATA_W | Head payloads, lane i at [i*DATA_W +: DATA_W] |
| min_free | output | $clog2(DEPTH+1) | Free slots in the fullest lane |

## Verification
The bench targets timestamps that share a coarse value but differ in fine bits. A design that compared full timestamps would pack those into one lane. It also fills all lanes with the same coarse value so that placement fails. A design that stalled there, or that moved the current lane, would block the stream or misplace the next event. Further cases are a full lane with spreading off, where a lost or duplicated event would show in the drained lane, and spreading at the watermark, where a missed skip keeps events in lane 0. A shifted replay of one sequence exposes any dependence on absolute timestamp values.

// File: rtl/evt_disp_pkg.sv
package evt_disp_pkg;

    // Number of fine bits folded away to get the coarse timestamp.
    localparam int FINE_W = 3;

    // Outcome of the lane search for the event presented this cycle.
    typedef enum logic [1:0] {
        ACT_PLACE = 2'd0,
        ACT_STALL = 2'd1,
        ACT_DROP  = 2'd2
    } place_act_e;

    // Lane reached after stepping forward from base, wrapping at n.
    function automatic int wrap_lane(int base, int step, int n);
        return (base + step) % n;
    endfunction

endpackage

// File: rtl/evt_lane_fifo.sv
module evt_lane_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 24,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic [W-1:0]     din,
    output logic [W-1:0]     dout,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic          do_push;
    logic          do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    function automatic logic [PW-1:0] ptr_next(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= ptr_next(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= ptr_next(rd_ptr);
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/evt_lane_select.sv
module evt_lane_select
    import evt_disp_pkg::*;
#(
    parameter int LANES = 8,
    parameter int CW    = 13,
    parameter int CNT_W = 3,
    parameter int HWM   = 2,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic [LANE_W-1:0]      cur,
    input  logic [CW-1:0]          coarse,
    input  logic [LANES*CW-1:0]    last_flat,
    input  logic [LANES-1:0]       last_vld,
    input  logic [LANES*CNT_W-1:0] counts,
    input  logic [LANES-1:0]       full,
    input  logic                   spread_en,
    output place_act_e             act,
    output logic [LANE_W-1:0]      sel
);
    logic [LANES-1:0]  fits;
    logic [LANES-1:0]  below_hwm;
    logic [LANE_W-1:0] order [LANES];
    logic              fit_found;
    logic [LANE_W-1:0] fit_sel;
    logic              sp_found;
    logic [LANE_W-1:0] sp_sel;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign fits[i]      = !last_vld[i] || (coarse > last_flat[i*CW +: CW]);
        assign below_hwm[i] = counts[i*CNT_W +: CNT_W] < CNT_W'(HWM);
        assign order[i]     = LANE_W'(wrap_lane(int'(cur), i, LANES));
    end

    // Walk from the farthest lane back to the current one so that the
    // nearest qualifying lane in circular order is the one that remains.
    always_comb begin
        fit_found = 1'b0;
        fit_sel   = cur;
        sp_found  = 1'b0;
        sp_sel    = cur;
        for (int j = LANES - 1; j >= 0; j--) begin
            if (fits[order[j]]) begin
                fit_found = 1'b1;
                fit_sel   = order[j];
                if (below_hwm[order[j]]) begin
                    sp_found = 1'b1;
                    sp_sel   = order[j];
                end
            end
        end
    end

    always_comb begin
        if (spread_en && sp_found) begin
            act = ACT_PLACE;
            sel = sp_sel;
        end else if (fit_found) begin
            act = full[fit_sel] ? ACT_STALL : ACT_PLACE;
            sel = fit_sel;
        end else begin
            act = ACT_DROP;
            sel = cur;
        end
    end
endmodule

// File: rtl/evt_min_free.sv
module evt_min_free #(
    parameter int LANES = 8,
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [LANES*CNT_W-1:0] counts,
    output logic [CNT_W-1:0]       min_free
);
    logic [CNT_W-1:0] peak;

    always_comb begin
        peak = '0;
        for (int i = 0; i < LANES; i++) begin
            if (counts[i*CNT_W +: CNT_W] > peak) begin
                peak = counts[i*CNT_W +: CNT_W];
            end
        end
    end

    assign min_free = CNT_W'(DEPTH) - peak;
endmodule

// File: rtl/evt_lane_dispatcher.sv
module evt_lane_dispatcher
    import evt_disp_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int DEPTH  = 4,
    parameter int TS_W   = 16,
    parameter int DATA_W = 8,
    parameter int HWM    = 2,
    localparam int CW     = TS_W - FINE_W,
    localparam int LANE_W = $clog2(LANES),
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int EW     = TS_W + DATA_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    spread_en,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [TS_W-1:0]         in_ts,
    input  logic [DATA_W-1:0]       in_data,
    output logic                    seq_err,
    output logic [LANES-1:0]        lane_valid,
    input  logic [LANES-1:0]        lane_pop,
    output logic [LANES*TS_W-1:0]   lane_ts,
    output logic [LANES*DATA_W-1:0] lane_data,
    output logic [CNT_W-1:0]        min_free
);
    logic [LANE_W-1:0]      cur_q;
    logic [CW-1:0]          last_q [LANES];
    logic [LANES-1:0]       last_vld_q;
    logic [LANES*CW-1:0]    last_flat;
    logic [LANES*CNT_W-1:0] counts;
    logic [LANES-1:0]       lane_full;
    logic [LANES-1:0]       lane_empty;
    logic [LANES-1:0]       wr_en;
    logic [CW-1:0]          in_coarse;
    place_act_e             act;
    logic [LANE_W-1:0]      sel;
    logic                   accept;
    logic                   place_ok;

    assign in_coarse = in_ts[TS_W-1:FINE_W];
    assign in_ready  = (act != ACT_STALL);
    assign accept    = in_valid && in_ready;
    assign place_ok  = accept && (act == ACT_PLACE);

    evt_lane_select #(
        .LANES (LANES),
        .CW    (CW),
        .CNT_W (CNT_W),
        .HWM   (HWM)
    ) u_select (
        .cur       (cur_q),
        .coarse    (in_coarse),
        .last_flat (last_flat),
        .last_vld  (last_vld_q),
        .counts    (counts),
        .full      (lane_full),
        .spread_en (spread_en),
        .act       (act),
        .sel       (sel)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lanes
        logic [EW-1:0] head;

        assign last_flat[i*CW +: CW] = last_q[i];
        assign wr_en[i]              = place_ok && (sel == LANE_W'(i));

        evt_lane_fifo #(
            .DEPTH (DEPTH),
            .W     (EW)
        ) u_fifo (
            .clk   (clk),
            .rst   (rst),
            .push  (wr_en[i]),
            .pop   (lane_pop[i]),
            .din   ({in_ts, in_data}),
            .dout  (head),
            .count (counts[i*CNT_W +: CNT_W]),
            .empty (lane_empty[i]),
            .full  (lane_full[i])
        );

        assign lane_valid[i]                  = !lane_empty[i];
        assign lane_ts[i*TS_W +: TS_W]        = head[EW-1:DATA_W];
        assign lane_data[i*DATA_W +: DATA_W]  = head[DATA_W-1:0];
    end

    evt_min_free #(
        .LANES (LANES),
        .DEPTH (DEPTH)
    ) u_min_free (
        .counts   (counts),
        .min_free (min_free)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q      <= '0;
            last_vld_q <= '0;
            seq_err    <= 1'b0;
            for (int i = 0; i < LANES; i++) begin
                last_q[i] <= '0;
            end
        end else begin
            seq_err <= accept && (act == ACT_DROP);
            if (place_ok) begin
                cur_q           <= sel;
                last_q[sel]     <= in_coarse;
                last_vld_q[sel] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/evt_disp_chk.sv
module evt_disp_chk #(
    parameter int LANES = 8,
    parameter int CW    = 13,
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic                 seq_err,
    input logic [CNT_W-1:0]     min_free,
    input logic [LANES-1:0]     wr_en,
    input logic [LANES-1:0]     lane_full,
    input logic [LANES-1:0]     last_vld,
    input logic [LANES*CW-1:0]  last_flat,
    input logic [CW-1:0]        wr_coarse
);
    AST_RESET_FREE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (min_free == CNT_W'(DEPTH))) else $error("reset free"); // R1

    AST_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_en)) else $error("multi write"); // R3

    AST_ERR_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (seq_err && !$past(rst)) |-> $past(in_valid && in_ready)) else $error("err w/o accept"); // R5

    AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && wr_en == '0) |=> seq_err) else $error("drop w/o err"); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (wr_en & lane_full) == '0) else $error("write to full lane"); // R6

    for (genvar i = 0; i < LANES; i++) begin : g_ord
        AST_LANE_ORDER: assert property (@(posedge clk) disable iff (rst)
            (wr_en[i] && last_vld[i]) |-> (wr_coarse > last_flat[i*CW +: CW]))
            else $error("lane order"); // R2
    end
endmodule

bind evt_lane_dispatcher evt_disp_chk #(
    .LANES (LANES),
    .CW    (CW),
    .DEPTH (DEPTH)
) u_disp_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .seq_err   (seq_err),
    .min_free  (min_free),
    .wr_en     (wr_en),
    .lane_full (lane_full),
    .last_vld  (last_vld_q),
    .last_flat (last_flat),
    .wr_coarse (in_coarse)
);

// File: tb/test_evt_lane_dispatcher.sv
module test_evt_lane_dispatcher;
    localparam int CLK_PERIOD = 10;
    localparam int LANES  = 8;
    localparam int DEPTH  = 4;
    localparam int TS_W   = 16;
    localparam int DATA_W = 8;
    localparam int HWM    = 2;
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int EW     = TS_W + DATA_W;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    spread_en = 1'b0;
    logic                    in_valid = 1'b0;
    logic                    in_ready;
    logic [TS_W-1:0]         in_ts = '0;
    logic [DATA_W-1:0]       in_data = '0;
    logic                    seq_err;
    logic [LANES-1:0]        lane_valid;
    logic [LANES-1:0]        lane_pop = '0;
    logic [LANES*TS_W-1:0]   lane_ts;
    logic [LANES*DATA_W-1:0] lane_data;
    logic [CNT_W-1:0]        min_free;

    evt_lane_dispatcher #(
        .LANES (LANES), .DEPTH (DEPTH), .TS_W (TS_W),
        .DATA_W (DATA_W), .HWM (HWM)
    ) i_evt_lane_dispatcher (
        .clk (clk), .rst (rst), .spread_en (spread_en),
        .in_valid (in_valid), .in_ready (in_ready),
        .in_ts (in_ts), .in_data (in_data), .seq_err (seq_err),
        .lane_valid (lane_valid), .lane_pop (lane_pop),
        .lane_ts (lane_ts), .lane_data (lane_data), .min_free (min_free)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference model built from the requirements
    int          m_cur;
    int          m_last [LANES];
    bit          m_vld  [LANES];
    int          m_cnt  [LANES];
    logic [EW-1:0] exp_q [LANES][$];
    logic [DATA_W-1:0] next_data = 8'h10;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit m_fits(int l, int c);
        return !m_vld[l] || (c > m_last[l]);
    endfunction

    function automatic int m_pick(int c);
        int fit = -1;
        int sp  = -1;
        for (int j = 0; j < LANES; j++) begin
            int l = (m_cur + j) % LANES;
            if (m_fits(l, c)) begin
                if (fit < 0) fit = l;
                if (sp < 0 && m_cnt[l] < HWM) sp = l;
            end
        end
        if (spread_en && sp >= 0) return sp;
        return fit;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        lane_pop = '0;
        @(posedge clk);
        @(posedge clk);
        #1;
        rst = 1'b0;
        m_cur = 0;
        for (int l = 0; l < LANES; l++) begin
            m_last[l] = 0;
            m_vld[l]  = 1'b0;
            m_cnt[l]  = 0;
            exp_q[l].delete();
        end
    endtask

    // Driver: offers one event, predicts its lane and queues the expectation
    task automatic send(input logic [TS_W-1:0] ts, input string req, output int lane);
        int c = int'(ts >> 3);
        lane = m_pick(c);
        @(negedge clk);
        in_ts    = ts;
        in_data  = next_data;
        in_valid = 1'b1;
        #1;
        check(in_ready == 1'b1, req, "in_ready on offer", in_ready, 1);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        if (lane < 0) begin
            check(seq_err == 1'b1, "R5", "seq_err after drop", seq_err, 1);
        end else begin
            check(seq_err == 1'b0, req, "seq_err after placement", seq_err, 0);
            exp_q[lane].push_back({ts, next_data});
            m_cnt[lane]++;
            m_cur = lane;
            m_last[lane] = c;
            m_vld[lane] = 1'b1;
        end
        next_data++;
    endtask

    // Monitor: pops one lane head and compares it against the scoreboard
    task automatic pop_one(input int l, input string req);
        logic [EW-1:0] exp = exp_q[l].pop_front();
        @(negedge clk);
        check(lane_valid[l] == 1'b1, req, $sformatf("lane %0d valid", l), lane_valid[l], 1);
        check(lane_ts[l*TS_W +: TS_W] == exp[EW-1:DATA_W], req,
              $sformatf("lane %0d ts", l), lane_ts[l*TS_W +: TS_W], exp[EW-1:DATA_W]);
        check(lane_data[l*DATA_W +: DATA_W] == exp[DATA_W-1:0], req,
              $sformatf("lane %0d data", l), lane_data[l*DATA_W +: DATA_W], exp[DATA_W-1:0]);
        lane_pop[l] = 1'b1;
        @(posedge clk);
        #1;
        lane_pop[l] = 1'b0;
        m_cnt[l]--;
    endtask

    task automatic drain_all(input string req);
        for (int l = 0; l < LANES; l++) begin
            while (exp_q[l].size() > 0) pop_one(l, req);
            check(lane_valid[l] == 1'b0, req, $sformatf("lane %0d empty", l), lane_valid[l], 0);
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        int lane;
        int run_a [6];
        int run_b [6];
        int seq_ts [6] = '{80, 83, 75, 96, 88, 95};
        int exp_a  [6] = '{0, 1, 2, 2, 3, 4};

        // R1: reset state
        do_reset();
        #1;
        check(lane_valid == '0, "R1", "lanes empty", lane_valid, 0);
        check(min_free == CNT_W'(DEPTH), "R1", "min_free", min_free, DEPTH);
        check(seq_err == 1'b0, "R1", "seq_err", seq_err, 0);
        check(in_ready == 1'b1, "R1", "in_ready", in_ready, 1);

        // R2: rising coarse stream stays in lane 0
        send(16'd8,  "R2", lane);
        send(16'd16, "R2", lane);
        send(16'd40, "R2", lane);
        check(lane == 0, "R2", "model lane", lane, 0);
        check(min_free == CNT_W'(DEPTH - 3), "R8", "min_free after 3", min_free, DEPTH - 3);
        drain_all("R9");

        // R4: equal coarse, differing fine bits
        do_reset();
        send(16'd16, "R4", lane);
        send(16'd17, "R4", lane);
        check(lane == 1, "R4", "model lane", lane, 1);
        send(16'd23, "R4", lane);
        send(16'd24, "R4", lane);
        check(lane == 2, "R3", "model lane", lane, 2);
        drain_all("R4");

        // R5, R10, R3: all lanes blocked, then wrap
        do_reset();
        for (int k = 0; k < LANES; k++) send(16'd40, "R3", lane);
        check(min_free == CNT_W'(DEPTH - 1), "R8", "min_free one each", min_free, DEPTH - 1);
        send(16'd40, "R5", lane);
        check(lane == -1, "R5", "model drop", lane, -1);
        check(min_free == CNT_W'(DEPTH - 1), "R5", "lanes untouched", min_free, DEPTH - 1);
        send(16'd32, "R5", lane);
        send(16'd48, "R10", lane);
        check(lane == 7, "R10", "model lane", lane, 7);
        send(16'd48, "R3", lane);
        check(lane == 0, "R3", "model wrap", lane, 0);
        drain_all("R3");

        // R6: full lane back-pressure with spreading off
        do_reset();
        send(16'd8,  "R6", lane);
        send(16'd16, "R6", lane);
        send(16'd24, "R6", lane);
        send(16'd32, "R6", lane);
        check(min_free == '0, "R8", "min_free full", min_free, 0);
        @(negedge clk);
        in_ts = 16'd40;
        in_data = next_data;
        in_valid = 1'b1;
        #1;
        check(in_ready == 1'b0, "R6", "stall on full lane", in_ready, 0);
        @(posedge clk);
        #1;
        check(min_free == '0, "R6", "no write while stalled", min_free, 0);
        pop_one(0, "R6");
        check(in_ready == 1'b1, "R6", "ready after pop", in_ready, 1);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        exp_q[0].push_back({16'd40, next_data});
        m_cnt[0]++;
        m_last[0] = 5;
        next_data++;
        drain_all("R6");

        // R7: watermark spreading
        do_reset();
        spread_en = 1'b1;
        send(16'd8,  "R7", lane);
        send(16'd16, "R7", lane);
        send(16'd24, "R7", lane);
        check(lane == 1, "R7", "model skip", lane, 1);
        send(16'd32, "R7", lane);
        send(16'd40, "R7", lane);
        check(lane == 2, "R7", "model skip 2", lane, 2);
        drain_all("R7");
        spread_en = 1'b0;

        // R11: shifted replay gives identical lanes
        do_reset();
        for (int k = 0; k < 6; k++) begin
            send(TS_W'(seq_ts[k]), "R11", lane);
            run_a[k] = lane;
            check(lane == exp_a[k], "R3", "model lane", lane, exp_a[k]);
        end
        drain_all("R11");
        do_reset();
        for (int k = 0; k < 6; k++) begin
            send(TS_W'(seq_ts[k] + 800), "R11", lane);
            run_b[k] = lane;
            check(run_b[k] == run_a[k], "R11", "offset lane", run_b[k], run_a[k]);
        end
        drain_all("R11");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule